// File: doc/BRIEF.md
# Wakeup Pin Monitor with Configuration Register Bank

This block stays powered while the main processor sleeps and watches a parameterized set of wakeup pins. Each pin has its own configuration: it can be armed for a rising edge, a falling edge, both edges, a high level, or (with no other option set) a low level. A qualifying event sets a sticky status bit for that pin. Status bits are recorded whatever the enable setting is. The single wake request goes high only when some status bit is set and its enable bit is also set.

Software reaches the block through a simple word-oriented read/write port that takes byte addresses. The map starts with two 32-bit general storage words. Five banks of per-pin words follow, in a fixed order: enable, falling-edge arm, rising-edge arm, level-high select and status. Each bank holds ceil(NUM_PINS/32) words. Before sleep, software writes zero to the status words to clear them. After wake, it reads the status words to see which pins fired.

Top module: `wake_monitor`

## Requirements
- R1: After reset every storage word and every per-pin bank reads zero and `wake_o` is low.
- R2: Byte address 0x00 and 0x04 hold two 32-bit storage words that read back exactly what was written. Word i of bank k lives at byte address (k*W + i + 2)*4, where W = ceil(NUM_PINS/32) and k is 0 enable, 1 falling-edge, 2 rising-edge, 3 level-high, 4 status. Pin p uses bit p%32 of word p/32.
- R3: Bits of the per-pin banks that belong to no existing pin ignore writes and always read zero.
- R4: An access whose address has bits [1:0] nonzero, or whose word index lies past the status bank, writes nothing and returns zero.
- R5: With its rising-edge bit set, a pin sets its status on a 0-to-1 transition and not on a 1-to-0 transition.
- R6: With its falling-edge bit set, a pin sets its status on a 1-to-0 transition. With both edge bits set, either transition sets it.
- R7: With its level-high bit set, a pin sets its status for as long as it is held high.
- R8: With the level-high bit and both edge bits clear, a pin sets its status for as long as it is held low.
- R9: Status bits are sticky. Writing 0 to a status bit clears it, and writing 1 leaves it unchanged. An event in the same cycle as a clearing write leaves the bit set.
- R10: `wake_o` is the OR over pins of (status AND enable), delayed by one register. A status bit set on a disabled pin does not raise it.
- R11: A pin change driven just after clock edge 0 sets status at edge 3 and raises `wake_o` at edge 4. The path is two synchronizer flops, one previous-sample flop, the status register and the wake register.
- R12: A read returns its data on `bus_rdata` one clock after the request, and `bus_rdata` holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | NUM_PINS | Asynchronous wakeup pins |
| bus_en | input | 1 | Access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | addr_bits(NUM_PINS) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| wake_o | output | 1 | Wake request |

## Verification
The bench drives a rising edge on an armed pin and samples `wake_o` after the third and after the fourth clock edge. A design with one synchronizer flop too many or too few raises the request a cycle off. It clears a status bit while a level-high pin is still held high; a design where the write beats the event would read zero there. It arms one edge and drives the opposite edge, which catches swapped rising and falling banks. It also sets status on a disabled pin, which catches a wake request that ignores the enable gate. A write of all ones to the last partial word and to a misaligned address shows whether padding bits or misaligned accesses leak into the stored state.

// File: rtl/wm_pkg.sv
`timescale 1ns/1ps
package wm_pkg;
    localparam int WORD_W      = 32;
    localparam int TIMER_WORDS = 2;
    localparam int NUM_BANKS   = 5;

    // Bank order is fixed by the address map (software decodes it).
    typedef enum int unsigned {
        BANK_ENABLE = 0,
        BANK_FALL   = 1,
        BANK_RISE   = 2,
        BANK_POL    = 3,
        BANK_STATUS = 4
    } bank_e;

    function automatic int words_for(input int pins);
        return (pins + WORD_W - 1) / WORD_W;
    endfunction

    function automatic int addr_bits(input int pins);
        return $clog2(TIMER_WORDS + NUM_BANKS * words_for(pins)) + 2;
    endfunction
endpackage

// File: rtl/wm_sync_edge.sv
`timescale 1ns/1ps
module wm_sync_edge #(
    parameter int NUM_PINS = 40
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pins_i,
    output logic [NUM_PINS-1:0] lvl_o,
    output logic [NUM_PINS-1:0] rise_o,
    output logic [NUM_PINS-1:0] fall_o
);
    typedef struct packed {
        logic [NUM_PINS-1:0] meta;
        logic [NUM_PINS-1:0] sync;
        logic [NUM_PINS-1:0] prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.meta = pins_i;
        sync_d.sync = sync_q.meta;
        sync_d.prev = sync_q.sync;
    end

    // Chain resets to the idle-high level so release from reset makes no edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign lvl_o  = sync_q.sync;
    assign rise_o = sync_q.sync & ~sync_q.prev;
    assign fall_o = ~sync_q.sync & sync_q.prev;
endmodule

// File: rtl/wm_event_detect.sv
`timescale 1ns/1ps
module wm_event_detect #(
    parameter int NUM_PINS = 40
) (
    input  logic [NUM_PINS-1:0] lvl_i,
    input  logic [NUM_PINS-1:0] rise_i,
    input  logic [NUM_PINS-1:0] fall_i,
    input  logic [NUM_PINS-1:0] cfg_rise_i,
    input  logic [NUM_PINS-1:0] cfg_fall_i,
    input  logic [NUM_PINS-1:0] cfg_pol_i,
    output logic [NUM_PINS-1:0] hit_o
);
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic edge_hit;
        logic level_hit;
        assign edge_hit  = (cfg_rise_i[p] & rise_i[p]) | (cfg_fall_i[p] & fall_i[p]);
        // Level-high when selected; level-low only when no edge is armed.
        assign level_hit = cfg_pol_i[p] ? lvl_i[p]
                                        : (~cfg_rise_i[p] & ~cfg_fall_i[p] & ~lvl_i[p]);
        assign hit_o[p]  = edge_hit | level_hit;
    end
endmodule

// File: rtl/wm_regbank.sv
`timescale 1ns/1ps
module wm_regbank
    import wm_pkg::*;
#(
    parameter int NUM_PINS = 40,
    parameter int ADDR_W   = addr_bits(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_en,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    input  logic [NUM_PINS-1:0] hit_i,
    output logic [WORD_W-1:0]   bus_rdata,
    output logic [NUM_PINS-1:0] en_o,
    output logic [NUM_PINS-1:0] fall_o,
    output logic [NUM_PINS-1:0] rise_o,
    output logic [NUM_PINS-1:0] pol_o,
    output logic [NUM_PINS-1:0] stat_o
);
    localparam int WORDS = words_for(NUM_PINS);
    localparam int PAD_W = WORDS * WORD_W;
    localparam int WI_W  = ADDR_W - 2;
    localparam logic [PAD_W-1:0] PIN_MASK = {PAD_W{1'b1}} >> (PAD_W - NUM_PINS);

    typedef struct packed {
        logic [WORD_W-1:0]                  tmr0;
        logic [WORD_W-1:0]                  tmr1;
        logic [NUM_BANKS-1:0][PAD_W-1:0]    bank;
        logic [WORD_W-1:0]                  rdata;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [WI_W-1:0]   word_idx;
    logic              aligned;
    logic              wr_go;
    logic              rd_go;
    logic [WORD_W-1:0] rd_val;
    logic [PAD_W-1:0]  hit_pad;

    assign word_idx = bus_addr[ADDR_W-1:2];
    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign hit_pad  = PAD_W'(hit_i);

    always_comb begin
        regs_d = regs_q;
        wr_go  = bus_en & bus_we & aligned;
        rd_go  = bus_en & ~bus_we;
        rd_val = '0;

        if (aligned && word_idx == WI_W'(0)) begin
            rd_val = regs_q.tmr0;
            if (wr_go) regs_d.tmr0 = bus_wdata;
        end
        if (aligned && word_idx == WI_W'(1)) begin
            rd_val = regs_q.tmr1;
            if (wr_go) regs_d.tmr1 = bus_wdata;
        end

        for (int b = 0; b < NUM_BANKS; b++) begin
            for (int w = 0; w < WORDS; w++) begin
                if (aligned && word_idx == WI_W'(TIMER_WORDS + b * WORDS + w)) begin
                    rd_val = regs_q.bank[b][w*WORD_W +: WORD_W];
                    if (wr_go) begin
                        if (b == int'(BANK_STATUS)) begin
                            // Only zeros clear; ones keep the stored bit.
                            regs_d.bank[b][w*WORD_W +: WORD_W] =
                                regs_q.bank[b][w*WORD_W +: WORD_W] & bus_wdata;
                        end else begin
                            regs_d.bank[b][w*WORD_W +: WORD_W] = bus_wdata;
                        end
                    end
                end
            end
        end

        // New events win over a clearing write in the same cycle.
        regs_d.bank[BANK_STATUS] = regs_d.bank[BANK_STATUS] | hit_pad;

        for (int b = 0; b < NUM_BANKS; b++) begin
            regs_d.bank[b] = regs_d.bank[b] & PIN_MASK;
        end

        if (rd_go) regs_d.rdata = rd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign bus_rdata = regs_q.rdata;
    assign en_o      = regs_q.bank[BANK_ENABLE][NUM_PINS-1:0];
    assign fall_o    = regs_q.bank[BANK_FALL][NUM_PINS-1:0];
    assign rise_o    = regs_q.bank[BANK_RISE][NUM_PINS-1:0];
    assign pol_o     = regs_q.bank[BANK_POL][NUM_PINS-1:0];
    assign stat_o    = regs_q.bank[BANK_STATUS][NUM_PINS-1:0];
endmodule

// File: rtl/wake_monitor.sv
`timescale 1ns/1ps
module wake_monitor
    import wm_pkg::*;
#(
    parameter int NUM_PINS = 40
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_PINS-1:0]           pins_i,
    input  logic                          bus_en,
    input  logic                          bus_we,
    input  logic [addr_bits(NUM_PINS)-1:0] bus_addr,
    input  logic [31:0]                   bus_wdata,
    output logic [31:0]                   bus_rdata,
    output logic                          wake_o
);
    localparam int ADDR_W = addr_bits(NUM_PINS);

    logic [NUM_PINS-1:0] sync_lvl;
    logic [NUM_PINS-1:0] sync_rise;
    logic [NUM_PINS-1:0] sync_fall;
    logic [NUM_PINS-1:0] cfg_en;
    logic [NUM_PINS-1:0] cfg_fall;
    logic [NUM_PINS-1:0] cfg_rise;
    logic [NUM_PINS-1:0] cfg_pol;
    logic [NUM_PINS-1:0] stat_vec;
    logic [NUM_PINS-1:0] pin_hit;

    wm_sync_edge #(.NUM_PINS(NUM_PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i (pins_i),
        .lvl_o  (sync_lvl),
        .rise_o (sync_rise),
        .fall_o (sync_fall)
    );

    wm_event_detect #(.NUM_PINS(NUM_PINS)) u_detect (
        .lvl_i      (sync_lvl),
        .rise_i     (sync_rise),
        .fall_i     (sync_fall),
        .cfg_rise_i (cfg_rise),
        .cfg_fall_i (cfg_fall),
        .cfg_pol_i  (cfg_pol),
        .hit_o      (pin_hit)
    );

    wm_regbank #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .hit_i     (pin_hit),
        .bus_rdata (bus_rdata),
        .en_o      (cfg_en),
        .fall_o    (cfg_fall),
        .rise_o    (cfg_rise),
        .pol_o     (cfg_pol),
        .stat_o    (stat_vec)
    );

    typedef struct packed {
        logic wake;
    } wake_t;

    wake_t wake_d, wake_q;

    always_comb begin
        wake_d      = wake_q;
        wake_d.wake = |(stat_vec & cfg_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wake_q <= '0;
        end else begin
            wake_q <= wake_d;
        end
    end

    assign wake_o = wake_q.wake;
endmodule

// File: rtl/wake_monitor_chk.sv
`timescale 1ns/1ps
module wake_monitor_chk
    import wm_pkg::*;
#(
    parameter int NUM_PINS = 40
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           bus_en,
    input logic                           bus_we,
    input logic [addr_bits(NUM_PINS)-1:0] bus_addr,
    input logic [31:0]                    bus_rdata,
    input logic                           wake_o,
    input logic [NUM_PINS-1:0]            en_vec,
    input logic [NUM_PINS-1:0]            st_vec
);
    localparam int AW      = addr_bits(NUM_PINS);
    localparam int WORDS   = words_for(NUM_PINS);
    localparam int STAT_LO = TIMER_WORDS + int'(BANK_STATUS) * WORDS;
    localparam int STAT_HI = STAT_LO + WORDS - 1;

    logic stat_touch;
    logic rd_req;
    logic rd_misaligned;

    assign stat_touch = bus_en & bus_we & (bus_addr[1:0] == 2'b00)
                      & (int'(bus_addr[AW-1:2]) >= STAT_LO)
                      & (int'(bus_addr[AW-1:2]) <= STAT_HI);
    assign rd_req        = bus_en & ~bus_we;
    assign rd_misaligned = rd_req & (bus_addr[1:0] != 2'b00);

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !wake_o); // R1

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(stat_touch) |-> ((st_vec & $past(st_vec)) == $past(st_vec))); // R9

    AST_WAKE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> ($past(en_vec) != '0)); // R10

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_req) |-> $stable(bus_rdata)); // R12

    AST_MISALIGNED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_misaligned) |-> (bus_rdata == 32'h0)); // R4
endmodule

bind wake_monitor wake_monitor_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .wake_o    (wake_o),
    .en_vec    (cfg_en),
    .st_vec    (stat_vec)
);

// File: tb/tb_wake_monitor.sv
`timescale 1ns/1ps
module tb_wake_monitor;
    localparam int NP = 40;
    localparam int W  = wm_pkg::words_for(NP);
    localparam int AW = wm_pkg::addr_bits(NP);
    localparam logic [63:0] MASK = (64'd1 << NP) - 64'd1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NP-1:0] pins;
    logic          bus_en;
    logic          bus_we;
    logic [AW-1:0] bus_addr;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata;
    logic          wake_o;

    always #4 clk = ~clk;

    wake_monitor #(.NUM_PINS(NP)) dut (
        .clk(clk), .rst_n(rst_n), .pins_i(pins),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wake_o(wake_o)
    );

    // Model: bank 0 enable, 1 falling, 2 rising, 3 level-high, 4 status
    logic [63:0] m_bank [5];
    logic [31:0] m_t0, m_t1;
    int total = 0;
    int bad   = 0;
    bit done  = 0;

    function automatic int unsigned baddr(input int k, input int i);
        return (k * W + i + 2) * 4;
    endfunction

    function automatic logic [63:0] lvl_hit(input logic [NP-1:0] v);
        logic [63:0] r = '0;
        for (int p = 0; p < NP; p++) begin
            if (m_bank[3][p]) r[p] = v[p];
            else r[p] = !m_bank[2][p] && !m_bank[1][p] && !v[p];
        end
        return r;
    endfunction

    function automatic logic [63:0] edge_hit(input logic [NP-1:0] o, input logic [NP-1:0] n);
        logic [63:0] r = '0;
        for (int p = 0; p < NP; p++)
            r[p] = (m_bank[2][p] && !o[p] && n[p]) || (m_bank[1][p] && o[p] && !n[p]);
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_write(input logic [AW-1:0] a, input logic [31:0] d);
        int wi;
        if (a[1:0] == 2'b00) begin
            wi = int'(a >> 2);
            if (wi == 0) m_t0 = d;
            else if (wi == 1) m_t1 = d;
            else if (wi < 2 + 5 * W) begin
                int k = (wi - 2) / W;
                int i = (wi - 2) % W;
                if (k == 4) m_bank[4][i*32 +: 32] = m_bank[4][i*32 +: 32] & d;
                else m_bank[k][i*32 +: 32] = d;
            end
        end
        for (int k = 0; k < 5; k++) m_bank[k] = m_bank[k] & MASK;
        m_bank[4] = (m_bank[4] | lvl_hit(pins)) & MASK;
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        model_write(a, d);
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic set_pins(input logic [NP-1:0] v);
        logic [NP-1:0] o;
        @(negedge clk);
        o = pins;
        pins = v;
        m_bank[4] = (m_bank[4] | edge_hit(o, v) | lvl_hit(v)) & MASK;
        repeat (5) @(negedge clk);
    endtask

    task automatic check_all(input string req);
        logic [31:0] rv;
        repeat (2) @(negedge clk);
        check({req, " wake"}, 64'(wake_o), 64'(|(m_bank[4] & m_bank[0])));
        for (int i = 0; i < W; i++) begin
            bus_read(AW'(baddr(4, i)), rv);
            check({req, " status"}, 64'(rv), 64'(m_bank[4][i*32 +: 32]));
        end
    endtask

    task automatic clear_all();
        for (int k = 0; k < 4; k++)
            for (int i = 0; i < W; i++) bus_write(AW'(baddr(k, i)), 32'h0);
        set_pins('1);
        for (int i = 0; i < W; i++) bus_write(AW'(baddr(4, i)), 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        logic [31:0] held;
        void'($urandom(32'd20240611));
        for (int k = 0; k < 5; k++) m_bank[k] = '0;
        m_t0 = '0; m_t1 = '0;
        rst_n = 1'b0; pins = '1;
        bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: everything zero after reset
        check("R1 wake after reset", 64'(wake_o), 64'h0);
        for (int wi = 0; wi < 2 + 5 * W; wi++) begin
            bus_read(AW'(wi * 4), rv);
            check("R1 reset word", 64'(rv), 64'h0);
        end

        // R2: storage words and bank placement
        bus_write(AW'(0), 32'hDEAD_BEEF);
        bus_write(AW'(4), 32'h1234_5678);
        bus_read(AW'(0), rv); check("R2 word 0x00", 64'(rv), 64'hDEAD_BEEF);
        bus_read(AW'(4), rv); check("R2 word 0x04", 64'(rv), 64'h1234_5678);
        for (int k = 0; k < 4; k++) bus_write(AW'(baddr(k, 1)), 32'h10 + 32'(k));
        for (int k = 0; k < 4; k++) begin
            bus_read(AW'(baddr(k, 1)), rv);
            check("R2 bank word placement", 64'(rv), 64'h10 + 64'(k));
        end
        check_all("R2");
        clear_all();

        // R3: padding bits of the last word
        bus_write(AW'(baddr(0, W - 1)), 32'hFFFF_FFFF);
        bus_read(AW'(baddr(0, W - 1)), rv);
        check("R3 padding bits", 64'(rv), 64'(MASK[(W-1)*32 +: 32]));
        bus_write(AW'(baddr(0, W - 1)), 32'h0);

        // R4: misaligned and out-of-map accesses
        bus_write(AW'(baddr(0, 0) + 1), 32'hFFFF_FFFF);
        bus_read(AW'(baddr(0, 0)), rv);
        check("R4 misaligned write ignored", 64'(rv), 64'h0);
        bus_read(AW'(baddr(0, 0) + 2), rv);
        check("R4 misaligned read zero", 64'(rv), 64'h0);
        bus_write(AW'((2 + 5 * W) * 4), 32'hFFFF_FFFF);
        bus_read(AW'((2 + 5 * W) * 4), rv);
        check("R4 out-of-map read zero", 64'(rv), 64'h0);

        // R12: read data holds between reads
        bus_read(AW'(0), held);
        repeat (3) @(negedge clk);
        check("R12 rdata held", 64'(bus_rdata), 64'(held));

        // R5 + R11: rising edge on pin 3, exact latency
        bus_write(AW'(baddr(2, 0)), 32'h8);
        bus_write(AW'(baddr(0, 0)), 32'h8);
        set_pins(pins & ~(40'h8));
        check_all("R5 no hit while falling with rise armed");
        @(negedge clk);
        pins[3] = 1'b1;
        m_bank[4][3] = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11 wake low after third edge", 64'(wake_o), 64'h0);
        @(negedge clk);
        check("R11 wake high after fourth edge", 64'(wake_o), 64'h1);
        check_all("R5 rise");
        bus_write(AW'(baddr(4, 0)), 32'h0);
        set_pins(pins & ~(40'h8));
        check_all("R5 fall ignored");
        bus_read(AW'(baddr(4, 0)), rv);
        check("R5 status bit 3 after fall", 64'(rv[3]), 64'h0);

        // R6: falling and both edges
        bus_write(AW'(baddr(2, 0)), 32'h0);
        bus_write(AW'(baddr(1, 0)), 32'h8);
        set_pins(pins | 40'h8);
        check_all("R6 rise ignored with fall armed");
        set_pins(pins & ~(40'h8));
        bus_read(AW'(baddr(4, 0)), rv);
        check("R6 fall sets status", 64'(rv[3]), 64'h1);
        bus_write(AW'(baddr(2, 0)), 32'h8);
        bus_write(AW'(baddr(4, 0)), 32'h0);
        set_pins(pins | 40'h8);
        check_all("R6 both edges rise");
        bus_write(AW'(baddr(4, 0)), 32'h0);
        set_pins(pins & ~(40'h8));
        check_all("R6 both edges fall");
        clear_all();

        // R7 + R9: level high wins against a clear
        bus_write(AW'(baddr(3, 0)), 32'h20);
        bus_read(AW'(baddr(4, 0)), rv);
        check("R7 level high sets status", 64'(rv[5]), 64'h1);
        bus_write(AW'(baddr(4, 0)), 32'h0);
        bus_read(AW'(baddr(4, 0)), rv);
        check("R9 event wins over clear", 64'(rv[5]), 64'h1);
        set_pins(pins & ~(40'h20));
        bus_write(AW'(baddr(4, 0)), 32'h0);
        bus_read(AW'(baddr(4, 0)), rv);
        check("R9 clear after level drops", 64'(rv), 64'h0);
        clear_all();

        // R8 + R10: level low on a disabled pin of the second word
        set_pins(pins & ~(40'h1 << 33));
        bus_read(AW'(baddr(4, 1)), rv);
        check("R8 level low sets status", 64'(rv[1]), 64'h1);
        check("R10 disabled pin no wake", 64'(wake_o), 64'h0);
        bus_write(AW'(baddr(0, 1)), 32'h2);
        repeat (2) @(negedge clk);
        check("R10 enable raises wake", 64'(wake_o), 64'h1);
        clear_all();

        // R9: writing ones does not set status
        bus_write(AW'(baddr(4, 0)), 32'hFFFF_FFFF);
        bus_read(AW'(baddr(4, 0)), rv);
        check("R9 write one keeps zero", 64'(rv), 64'h0);

        // Random mix against the model
        for (int it = 0; it < 80; it++) begin
            int op = int'($urandom_range(0, 2));
            if (op == 0) begin
                logic [63:0] r = {$urandom, $urandom};
                set_pins(pins ^ r[NP-1:0]);
            end else if (op == 1) begin
                bus_write(AW'(baddr(int'($urandom_range(0, 3)), int'($urandom_range(0, W - 1)))),
                          $urandom);
            end else begin
                bus_write(AW'(baddr(4, int'($urandom_range(0, W - 1)))), $urandom);
            end
            check_all("R10 random");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule